// File: doc/BRIEF.md
# Serial Write Port for a Dot-Matrix LED Driver

This block is the device-side serial write logic of a four-character 5x7 dot-matrix LED driver. A host moves data in over a three-wire serial link: a data line, a shift clock and an active-low write enable. A register-select line picks the destination. Dot data fills a 160-bit shift register. A parallel dot latch sits behind it and feeds the display refresh, so the picture on show stays steady while the next one is shifted in. Control data fills an 8-bit shift register. Its top bit steers the lower seven bits into one of two control words.

The serial pins are asynchronous to the fast system clock. They are sampled through a synchronizer, and the block acts on the edges it detects there. The data output can report the last bit of the active shift register, so that several devices can be daisy-chained. It can also pass the data input straight through during control writes, so that a whole chain takes one control word at the same time. A synchronous active-low reset clears both control words, which puts the display to sleep. It leaves the dot data alone.

Top module: `ledmx_write_port`

## Requirements
- R1: While `wr_en_n` is low, every detected rising edge of `ser_clk` shifts `ser_din` into bit 0 of the selected shift register, and every older bit moves up by one. After 160 shifts, the first dot bit sent sits at bit 159.
- R2: The level of `reg_sel` is captured when `wr_en_n` falls: 0 selects the dot register, 1 selects the control register. A change of `reg_sel` while `wr_en_n` stays low does not change the destination.
- R3: After `wr_en_n` returns high, the dot shift register is copied into `dot_latch` as soon as `ser_clk` is low. While shifting goes on, `dot_latch` keeps its previous contents. A 1 in a latched bit means that LED is lit.
- R4: Control data is sent as 8 bits, most significant first. With bit 7 = 0, bits 6..0 go to `ctrl_word0`; with bit 7 = 1, they go to `ctrl_word1`. The word that is not selected keeps its value.
- R5: With `ctrl_word1` bit 0 = 0, `ser_dout` carries the top bit of the destination register: bit 7 of the control register, or bit 159 of the dot register.
- R6: With `ctrl_word1` bit 0 = 1 and the control register selected, `ser_dout` follows `ser_din` combinationally. Dot writes still use the R5 behaviour.
- R7: Reset (`rst_n` low at a `sys_clk` edge) clears both control words to zero, which sets the sleep bit (`ctrl_word0` bit 6) to 0. It leaves `dot_latch` unchanged.
- R8: Each write session transfers once. Edges of `ser_clk` while `wr_en_n` is high move no shift register, and they change neither the latch nor the control words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | Fast system clock that samples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock from the host |
| wr_en_n | input | 1 | Active-low write enable |
| reg_sel | input | 1 | Destination select, captured when wr_en_n falls |
| ser_din | input | 1 | Serial data in |
| ser_dout | output | 1 | Cascade output: register tail, or pass-through of ser_din |
| dot_latch | output | DOT_BITS | Latched dot pattern for the refresh logic |
| ctrl_word0 | output | CW_BITS | Brightness and sleep control word |
| ctrl_word1 | output | CW_BITS | Output-mode and prescaler control word |

## Verification
The bench builds the block with its default values: 160 dot bits, 7-bit control words and a two-stage synchronizer. This makes a full-length frame reachable, so the check that the first bit sent lands at bit 159 is a true boundary test. The 7-bit words keep bit 7 of the control shift register as the steering bit. With two synchronizer stages the pin-to-register latency stays short. A serial phase of eight system clocks then leaves stable windows in which the reference model is compared on every clock, including the pass-through path and the reset that must spare the dot latch.

// File: rtl/ledmx_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial write port of the LED driver.
package ledmx_pkg;
    // Destination of a write session, as captured from the register-select pin.
    typedef enum logic {
        DEST_DOT  = 1'b0,
        DEST_CTRL = 1'b1
    } dest_e;

    // One sample of the serial pins.
    typedef struct packed {
        logic en_n;
        logic sclk;
        logic sel;
        logic din;
    } pins_t;

    // Pin values that mean "idle": no write, shift clock low.
    localparam pins_t PINS_IDLE = '{en_n: 1'b1, sclk: 1'b0, sel: 1'b0, din: 1'b0};
endpackage

// File: rtl/ledmx_pin_sync.sv
`timescale 1ns/1ps
// ledmx_pin_sync
// Brings the asynchronous serial pins into the system clock domain through
// STAGES flops, and finds the edges of the shift clock and the write enable.
// Assumes every pin level lasts several system clocks, so that no edge is
// missed. All pins pass through the same chain, which keeps data aligned
// with its clock edge.
module ledmx_pin_sync
    import ledmx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  pins_t pins_in,
    output pins_t pins_s,
    output logic  sclk_rise,
    output logic  en_fall,
    output logic  en_rise
);
    pins_t [STAGES-1:0] chain;
    pins_t              prev;

    // Synchronizer chain, plus one more stage kept for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{PINS_IDLE}};
            prev  <= PINS_IDLE;
        end else begin
            chain[0] <= pins_in;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
            prev <= chain[STAGES-1];
        end
    end

    assign pins_s    = chain[STAGES-1];
    assign sclk_rise = pins_s.sclk & ~prev.sclk;
    assign en_fall   = ~pins_s.en_n & prev.en_n;
    assign en_rise   = pins_s.en_n & ~prev.en_n;
endmodule

// File: rtl/ledmx_shift_path.sv
`timescale 1ns/1ps
// ledmx_shift_path
// Holds the destination captured at the start of a session, the dot shift
// register and the control shift register. Assumes a shift pulse and a
// start-of-session pulse never come in the same system clock. The dot
// register has no reset; its contents survive a device reset.
module ledmx_shift_path
    import ledmx_pkg::*;
#(
    parameter int DOT_BITS  = 160,
    parameter int CTRL_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_pulse,
    input  logic                 start_pulse,
    input  logic                 sel_s,
    input  logic                 din_s,
    output dest_e                dest,
    output logic [DOT_BITS-1:0]  dot_sr,
    output logic [CTRL_BITS-1:0] ctrl_sr
);
    // Destination register: loaded only at the start of a session.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest <= DEST_DOT;
        end else if (start_pulse) begin
            dest <= dest_e'(sel_s);
        end
    end

    // Dot shift register: shifts toward the top bit, with no reset.
    always_ff @(posedge clk) begin
        if (shift_pulse && dest == DEST_DOT) begin
            dot_sr <= {dot_sr[DOT_BITS-2:0], din_s};
        end
    end

    // Control shift register: shifts toward the top bit, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_sr <= '0;
        end else if (shift_pulse && dest == DEST_CTRL) begin
            ctrl_sr <= {ctrl_sr[CTRL_BITS-2:0], din_s};
        end
    end

    // R1
    dot_shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_pulse && dest == DEST_DOT) |=>
            (dot_sr[0] == $past(din_s) && dot_sr[DOT_BITS-1:1] == $past(dot_sr[DOT_BITS-2:0])));

    // R2
    dest_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> (dest == dest_e'($past(sel_s))));

    // R2
    dest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_pulse |=> $stable(dest));
endmodule

// File: rtl/ledmx_transfer.sv
`timescale 1ns/1ps
// ledmx_transfer
// Arms a transfer when a write session ends, then copies the shift register
// into its target: the dot latch, or the control word chosen by the top bit
// of the control register. The copy happens on the first system clock in
// which the enable is high and the shift clock is low. Assumes the
// destination does not change between the end of a session and its transfer.
module ledmx_transfer
    import ledmx_pkg::*;
#(
    parameter int DOT_BITS = 160,
    parameter int CW_BITS  = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                end_pulse,
    input  logic                en_n_s,
    input  logic                sclk_s,
    input  dest_e               dest,
    input  logic [DOT_BITS-1:0] dot_sr,
    input  logic [CW_BITS:0]    ctrl_sr,
    output logic [DOT_BITS-1:0] dot_lat,
    output logic [CW_BITS-1:0]  cw0,
    output logic [CW_BITS-1:0]  cw1
);
    logic armed;
    logic commit;

    assign commit = armed & en_n_s & ~sclk_s;

    // Arm flag: set when a session ends, cleared by its single transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (end_pulse) begin
            armed <= 1'b1;
        end else if (commit) begin
            armed <= 1'b0;
        end
    end

    // Dot latch: loaded on transfer, left alone by reset.
    always_ff @(posedge clk) begin
        if (commit && dest == DEST_DOT) begin
            dot_lat <= dot_sr;
        end
    end

    // Control words: cleared by reset; the top bit steers the transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cw0 <= '0;
            cw1 <= '0;
        end else if (commit && dest == DEST_CTRL) begin
            if (ctrl_sr[CW_BITS]) begin
                cw1 <= ctrl_sr[CW_BITS-1:0];
            end else begin
                cw0 <= ctrl_sr[CW_BITS-1:0];
            end
        end
    end

    // R3
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n_s || sclk_s) |=> $stable(dot_lat));

    // R4
    word0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_sr[CW_BITS] |=> $stable(cw0));

    // R4
    word1_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_sr[CW_BITS] |=> $stable(cw1));

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (cw0 == '0 && cw1 == '0));
endmodule

// File: rtl/ledmx_write_port.sv
`timescale 1ns/1ps
// ledmx_write_port
// Top of the serial write port. It synchronizes the pins, shifts the data,
// transfers it to the dot latch or a control word, and drives the cascade
// output. Assumes the host holds each serial pin level for several system
// clocks. In pass-through mode the output follows the data pin with no
// register in the path.
module ledmx_write_port
    import ledmx_pkg::*;
#(
    parameter int DOT_BITS    = 160,
    parameter int CW_BITS     = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                sys_clk,
    input  logic                rst_n,
    input  logic                ser_clk,
    input  logic                wr_en_n,
    input  logic                reg_sel,
    input  logic                ser_din,
    output logic                ser_dout,
    output logic [DOT_BITS-1:0] dot_latch,
    output logic [CW_BITS-1:0]  ctrl_word0,
    output logic [CW_BITS-1:0]  ctrl_word1
);
    localparam int CTRL_BITS = CW_BITS + 1;
    localparam int PASS_BIT  = 0;

    pins_t                pins_raw;
    pins_t                pins_s;
    logic                 sclk_rise;
    logic                 en_fall;
    logic                 en_rise;
    dest_e                dest;
    logic [DOT_BITS-1:0]  dot_sr;
    logic [CTRL_BITS-1:0] ctrl_sr;

    assign pins_raw = '{en_n: wr_en_n, sclk: ser_clk, sel: reg_sel, din: ser_din};

    ledmx_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk       (sys_clk),
        .rst_n     (rst_n),
        .pins_in   (pins_raw),
        .pins_s    (pins_s),
        .sclk_rise (sclk_rise),
        .en_fall   (en_fall),
        .en_rise   (en_rise)
    );

    ledmx_shift_path #(
        .DOT_BITS  (DOT_BITS),
        .CTRL_BITS (CTRL_BITS)
    ) shift_i (
        .clk         (sys_clk),
        .rst_n       (rst_n),
        .shift_pulse (sclk_rise & ~pins_s.en_n),
        .start_pulse (en_fall),
        .sel_s       (pins_s.sel),
        .din_s       (pins_s.din),
        .dest        (dest),
        .dot_sr      (dot_sr),
        .ctrl_sr     (ctrl_sr)
    );

    ledmx_transfer #(
        .DOT_BITS (DOT_BITS),
        .CW_BITS  (CW_BITS)
    ) xfer_i (
        .clk       (sys_clk),
        .rst_n     (rst_n),
        .end_pulse (en_rise),
        .en_n_s    (pins_s.en_n),
        .sclk_s    (pins_s.sclk),
        .dest      (dest),
        .dot_sr    (dot_sr),
        .ctrl_sr   (ctrl_sr),
        .dot_lat   (dot_latch),
        .cw0       (ctrl_word0),
        .cw1       (ctrl_word1)
    );

    // Cascade output: pass-through for control writes in that mode, else the register tail.
    always_comb begin
        if (dest == DEST_CTRL && ctrl_word1[PASS_BIT]) begin
            ser_dout = ser_din;
        end else if (dest == DEST_CTRL) begin
            ser_dout = ctrl_sr[CTRL_BITS-1];
        end else begin
            ser_dout = dot_sr[DOT_BITS-1];
        end
    end
endmodule

// File: tb/ledmx_write_port_tb_top.sv
`timescale 1ns/1ps
// Bench: a behavioural model, updated when the bench moves a pin, is compared
// with the outputs on every clock once the synchronizer has settled.
module ledmx_write_port_tb_top;
    localparam int DOT  = 160;
    localparam int CW   = 7;
    localparam int HOLD = 8;

    logic sclk = 1'b0;
    always #4 sclk = ~sclk;

    logic rst_n, p_clk, p_en_n, p_sel, p_din;
    logic ser_dout;
    logic [DOT-1:0] dot_latch;
    logic [CW-1:0]  ctrl_word0, ctrl_word1;

    ledmx_write_port dut_i (
        .sys_clk    (sclk),
        .rst_n      (rst_n),
        .ser_clk    (p_clk),
        .wr_en_n    (p_en_n),
        .reg_sel    (p_sel),
        .ser_din    (p_din),
        .ser_dout   (ser_dout),
        .dot_latch  (dot_latch),
        .ctrl_word0 (ctrl_word0),
        .ctrl_word1 (ctrl_word1)
    );

    int total = 0;
    int bad   = 0;
    int quiet = 0;
    bit done  = 1'b0;

    // Reference model state
    logic [DOT-1:0] m_sr, m_known, m_lat, m_lat_known;
    logic [7:0]     m_csr;
    logic [CW-1:0]  m_cw0, m_cw1;
    bit             m_rs, m_pend;

    task automatic chk(string req, string what, logic [DOT-1:0] act, logic [DOT-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic void model_commit();
        if (p_en_n && !p_clk && m_pend) begin
            m_pend = 1'b0;
            if (!m_rs) begin
                m_lat       = m_sr;
                m_lat_known = m_known;
            end else if (m_csr[7]) begin
                m_cw1 = m_csr[6:0];
            end else begin
                m_cw0 = m_csr[6:0];
            end
        end
    endfunction

    // Per-clock comparison once the pins have been still long enough
    always @(posedge sclk) begin
        quiet = quiet + 1;
        #1;
        if (!done && rst_n && quiet >= 7) begin
            chk("R3", "dot latch", dot_latch & m_lat_known, m_lat & m_lat_known);
            chk("R4", "word0", DOT'(ctrl_word0), DOT'(m_cw0));
            chk("R4", "word1", DOT'(ctrl_word1), DOT'(m_cw1));
            if (m_rs && m_cw1[0]) begin
                chk("R6", "dout pass", DOT'(ser_dout), DOT'(p_din));
            end else if (m_rs) begin
                chk("R5", "dout ctrl", DOT'(ser_dout), DOT'(m_csr[7]));
            end else if (m_known[DOT-1]) begin
                chk("R5", "dout dot", DOT'(ser_dout), DOT'(m_sr[DOT-1]));
            end
        end
    end

    task automatic hold();
        repeat (HOLD) @(posedge sclk);
        @(negedge sclk);
    endtask

    task automatic set_sel(bit v);
        p_sel = v; quiet = 0;
        hold();
    endtask

    task automatic set_en(bit v);
        p_en_n = v; quiet = 0;
        if (!v) m_rs = p_sel; else m_pend = 1'b1;
        model_commit();
        hold();
    endtask

    task automatic tick(bit d);
        p_din = d; quiet = 0;
        hold();
        p_clk = 1'b1; quiet = 0;
        if (!p_en_n) begin
            if (m_rs) m_csr = {m_csr[6:0], d};
            else begin
                m_sr    = {m_sr[DOT-2:0], d};
                m_known = {m_known[DOT-2:0], 1'b1};
            end
        end
        hold();
        p_clk = 1'b0; quiet = 0;
        model_commit();
        hold();
    endtask

    task automatic write_frame(logic [DOT-1:0] pat, bit chk_out);
        set_sel(1'b0);
        set_en(1'b0);
        for (int i = DOT - 1; i >= 0; i--) tick(pat[i]);
        if (chk_out) chk("R6", "dot write keeps serial dout", DOT'(ser_dout), DOT'(pat[DOT-1]));
        set_en(1'b1);
    endtask

    task automatic write_ctrl(logic [7:0] b, bit chk_out);
        set_sel(1'b1);
        set_en(1'b0);
        for (int i = 7; i >= 0; i--) tick(b[i]);
        if (chk_out) chk("R5", "ctrl tail on dout", DOT'(ser_dout), DOT'(b[7]));
        set_en(1'b1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; quiet = 0;
        repeat (3) @(negedge sclk);
        m_cw0 = '0; m_cw1 = '0; m_csr = '0; m_rs = 1'b0; m_pend = 1'b0;
        rst_n = 1'b1; quiet = 0;
        hold();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge sclk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            finish_run();
        end
    end

    localparam logic [DOT-1:0] PAT_A = {5{32'hA5C3_1E97}};
    localparam logic [DOT-1:0] PAT_C = {32'hF00D_CAFE, 32'h1234_5678, 32'h9ABC_DEF0,
                                        32'h0F0F_0F0F, 32'h5555_AAAA};

    initial begin
        rst_n = 1'b0; p_clk = 1'b0; p_en_n = 1'b1; p_sel = 1'b0; p_din = 1'b0;
        m_sr = '0; m_known = '0; m_lat = '0; m_lat_known = '0;
        m_csr = '0; m_cw0 = '0; m_cw1 = '0; m_rs = 1'b0; m_pend = 1'b0;
        repeat (4) @(negedge sclk);
        rst_n = 1'b1;
        hold();

        // R7: reset state of both control words
        chk("R7", "word0 after reset", DOT'(ctrl_word0), '0);
        chk("R7", "word1 after reset", DOT'(ctrl_word1), '0);

        // R3: a whole frame reaches the latch
        write_frame(PAT_A, 1'b0);
        chk("R3", "frame A latched", dot_latch, PAT_A);

        // R1: first bit sent lands at bit 159; the latch holds while shifting
        set_sel(1'b0);
        set_en(1'b0);
        tick(1'b1);
        for (int i = 1; i < DOT; i++) tick(1'b0);
        chk("R3", "latch held during shift", dot_latch, PAT_A);
        chk("R5", "dot tail on dout", DOT'(ser_dout), DOT'(1'b1));
        set_en(1'b1);
        chk("R1", "first bit at top", dot_latch, {1'b1, {(DOT-1){1'b0}}});

        // R4: word 0 write leaves word 1
        write_ctrl(8'h5A, 1'b0);
        chk("R4", "word0 written", DOT'(ctrl_word0), DOT'(7'h5A));
        chk("R4", "word1 kept", DOT'(ctrl_word1), '0);

        // R4: word 1 write (pass-through on) leaves word 0
        write_ctrl(8'h81, 1'b1);
        chk("R4", "word1 written", DOT'(ctrl_word1), DOT'(7'h01));
        chk("R4", "word0 kept", DOT'(ctrl_word0), DOT'(7'h5A));

        // R6: pass-through follows the data pin during a control write
        set_sel(1'b1);
        set_en(1'b0);
        p_din = 1'b1; quiet = 0; hold();
        chk("R6", "dout follows din high", DOT'(ser_dout), DOT'(1'b1));
        p_din = 1'b0; quiet = 0; hold();
        chk("R6", "dout follows din low", DOT'(ser_dout), DOT'(1'b0));
        for (int i = 7; i >= 0; i--) tick(8'h3C >> i);
        set_en(1'b1);
        chk("R4", "word0 via pass mode", DOT'(ctrl_word0), DOT'(7'h3C));

        // R6: dot writes keep the serial tail even in pass mode
        write_frame(PAT_C, 1'b1);
        chk("R3", "frame C latched", dot_latch, PAT_C);

        // R2: select change in mid-session does not move the destination
        set_sel(1'b1);
        set_en(1'b0);
        for (int i = 7; i >= 4; i--) tick(8'h07 >> i);
        set_sel(1'b0);
        for (int i = 3; i >= 0; i--) tick(8'h07 >> i);
        set_en(1'b1);
        chk("R2", "word0 got data", DOT'(ctrl_word0), DOT'(7'h07));
        chk("R2", "latch untouched", dot_latch, PAT_C);

        // R8: leave pass mode, then clock with the enable high
        write_ctrl(8'h80, 1'b0);
        chk("R4", "word1 cleared", DOT'(ctrl_word1), '0);
        for (int i = 0; i < 5; i++) tick(1'b0);
        chk("R8", "ctrl tail unmoved", DOT'(ser_dout), DOT'(1'b1));
        chk("R8", "latch unchanged", dot_latch, PAT_C);
        chk("R8", "word0 unchanged", DOT'(ctrl_word0), DOT'(7'h07));

        // R7: reset clears words and spares the dot latch
        do_reset();
        chk("R7", "word0 cleared", DOT'(ctrl_word0), '0);
        chk("R7", "word1 cleared", DOT'(ctrl_word1), '0);
        chk("R7", "latch kept", dot_latch, PAT_C);

        // R3: writes still work after reset
        write_frame(PAT_A, 1'b0);
        chk("R3", "frame after reset", dot_latch, PAT_A);

        finish_run();
    end
endmodule